// File: doc/BRIEF.md
# Decoder Event Message Serializer

This block turns the outcome of a remote-entry decode into a short ten-bit frame for a host microcontroller. The decoder pulses a send strobe with a frame kind and a set of fields. The block then captures those fields and sends the frame most significant bit first. There are two frame kinds. An event frame carries the function code, the low-battery flag, the repeat flag and the stored-transmitter count. A learn-status frame carries the learn result, the overwrite flag and the same transmitter count.

The frame can go out in one of two ways. On a single wire, each bit is a width-modulated pulse that lasts three time units. On two wires, the bit level is held on the data line while a companion clock gives one high unit and one low unit per bit. A parameter sets the time unit as a number of system-clock cycles. The block reports busy from the moment a strobe is accepted until the stop bit ends. Strobes that arrive while a frame is in flight are dropped.

Top module: `evt_msg_ser`

## Requirements
- R1: Out of reset, and whenever no frame is in flight, `data_o`, `clk_o` and `busy_o` are all low.
- R2: With `kind_i`=0 (event), the ten bits leave in this order: 1, `func_i[3]`, `func_i[2]`, `func_i[1]`, `func_i[0]`, `vlow_i`, `rpt_i`, `txcnt_i[1]`, `txcnt_i[0]`, 1. Here `txcnt_i` is the number of stored transmitters minus one (00 means one, 11 means four).
- R3: With `kind_i`=1 (learn status), the ten bits leave in this order: 1, 0, 0, 0, 0, `lrn_ok_i`, `lrn_ovw_i`, `txcnt_i[1]`, `txcnt_i[0]`, 1. The function, battery and repeat inputs have no effect on this frame.
- R4: The first bit (start) and the last bit (stop) of every frame are 1.
- R5: With `two_wire_i`=0 (single wire), each bit lasts 3×UNIT_CYC cycles. A 1 is high for one unit and then low for two. A 0 is high for two units and then low for one. `clk_o` stays low for the whole frame.
- R6: With `two_wire_i`=1 (two wire), each bit lasts 2×UNIT_CYC cycles. `data_o` holds the bit level for the whole bit. `clk_o` is high for the first unit and low for the second. `data_o` changes only in the cycle where `clk_o` rises.
- R7: `busy_o` rises in the cycle after the clock edge that accepts the strobe. It stays high for exactly 10×3×UNIT_CYC cycles (single wire) or 10×2×UNIT_CYC cycles (two wire). The first bit is visible in that same first busy cycle.
- R8: A strobe seen while `busy_o` is high is ignored. It changes neither the frame in flight nor the frame that follows.
- R9: The frame kind, the wire mode and all the fields are captured at the accepting edge. Changes on those inputs during the frame do not alter it.
- R10: A strobe that is held high starts the next frame at the first clock edge after `busy_o` has fallen. That frame uses the input values present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| send_i | input | 1 | Request to send a frame, sampled on each rising clock edge |
| kind_i | input | 1 | Frame kind: 0 event, 1 learn status |
| two_wire_i | input | 1 | Output mode: 0 single-wire width-modulated, 1 data plus clock |
| func_i | input | 4 | Function code for event frames |
| vlow_i | input | 1 | Low-battery flag for event frames |
| rpt_i | input | 1 | Repeat flag for event frames |
| txcnt_i | input | 2 | Stored transmitters minus one |
| lrn_ok_i | input | 1 | Learn succeeded flag for learn frames |
| lrn_ovw_i | input | 1 | Earlier slot replaced flag for learn frames |
| data_o | output | 1 | Serial data line |
| clk_o | output | 1 | Companion clock in two-wire mode, low otherwise |
| busy_o | output | 1 | High while a frame is in flight |

## Verification
The bench aims at the last unit of the stop bit. A design that ends one unit early or one unit late gives the wrong busy length and mistimes a back-to-back frame. Strobes are pulsed in the middle of a frame with different kinds and modes. A design that rearms while busy would restart or corrupt the frame in flight. Inputs are also changed while a frame is going out. A design that reads the fields live would show the new values in the later bits. Learn frames are sent with every function bit set, which catches a design that leaks the event fields into the four zero bits.

// File: rtl/evt_msg_pkg.sv
package evt_msg_pkg;
  localparam int unsigned FRAME_BITS = 10;
  localparam int unsigned PH_ONE_W   = 3;
  localparam int unsigned PH_TWO_W   = 2;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);

  typedef enum logic {
    LINK_ONE_WIRE = 1'b0,
    LINK_TWO_WIRE = 1'b1
  } link_e;

  typedef enum logic {
    MSG_EVENT = 1'b0,
    MSG_LEARN = 1'b1
  } msg_e;

  typedef struct packed {
    logic [3:0] func;
    logic       vlow;
    logic       rpt;
    logic [1:0] txcnt;
    logic       lrn_ok;
    logic       lrn_ovw;
  } fields_t;

  typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/evt_msg_rstsync.sv
module evt_msg_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/evt_msg_frame.sv
module evt_msg_frame
  import evt_msg_pkg::*;
(
  input  msg_e    kind_i,
  input  fields_t fld_i,
  output frame_t  frame_o
);
  logic [3:0] body_hi;
  logic [1:0] body_mid;

  always_comb begin
    if (kind_i == MSG_LEARN) begin
      body_hi  = 4'b0000;
      body_mid = {fld_i.lrn_ok, fld_i.lrn_ovw};
    end else begin
      body_hi  = fld_i.func;
      body_mid = {fld_i.vlow, fld_i.rpt};
    end
    frame_o = {1'b1, body_hi, body_mid, fld_i.txcnt, 1'b1};
  end
endmodule

// File: rtl/evt_msg_prescale.sv
module evt_msg_prescale #(
  parameter int unsigned UNIT_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = clr_i || run_i || (cnt_q != '0);
    if (clr_i || !run_i || tick_o) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_msg_seq.sv
module evt_msg_seq
  import evt_msg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_i,
  input  link_e      link_i,
  input  frame_t     frame_i,
  input  logic       tick_i,
  output logic       accept_o,
  output logic       busy_o,
  output link_e      link_o,
  output logic       bit_o,
  output logic [1:0] phase_o
);
  logic             busy_q, busy_d;
  link_e            link_q, link_d;
  frame_t           shreg_q, shreg_d;
  logic [BIT_W-1:0] bitcnt_q, bitcnt_d;
  logic [1:0]       phase_q, phase_d;
  logic             last_phase, last_bit, st_en;

  assign accept_o   = send_i && !busy_q;
  assign last_phase = (link_q == LINK_TWO_WIRE) ? (phase_q == 2'(PH_TWO_W - 1))
                                                : (phase_q == 2'(PH_ONE_W - 1));
  assign last_bit   = (bitcnt_q == BIT_W'(FRAME_BITS - 1));
  assign st_en      = accept_o || (busy_q && tick_i);

  always_comb begin
    busy_d   = busy_q;
    link_d   = link_q;
    shreg_d  = shreg_q;
    bitcnt_d = bitcnt_q;
    phase_d  = phase_q;
    if (accept_o) begin
      busy_d   = 1'b1;
      link_d   = link_i;
      shreg_d  = frame_i;
      bitcnt_d = '0;
      phase_d  = '0;
    end else if (last_phase) begin
      phase_d = '0;
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        bitcnt_d = bitcnt_q + 1'b1;
        shreg_d  = {shreg_q[FRAME_BITS-2:0], 1'b0};
      end
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      link_q   <= LINK_ONE_WIRE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      phase_q  <= '0;
    end else if (st_en) begin
      busy_q   <= busy_d;
      link_q   <= link_d;
      shreg_q  <= shreg_d;
      bitcnt_q <= bitcnt_d;
      phase_q  <= phase_d;
    end
  end

  assign busy_o  = busy_q;
  assign link_o  = link_q;
  assign bit_o   = shreg_q[FRAME_BITS-1];
  assign phase_o = phase_q;
endmodule

// File: rtl/evt_msg_enc.sv
module evt_msg_enc
  import evt_msg_pkg::*;
(
  input  logic       busy_i,
  input  link_e      link_i,
  input  logic       bit_i,
  input  logic [1:0] phase_i,
  output logic       data_o,
  output logic       clk_o
);
  logic pwm_level;

  // single wire: unit 0 always high, unit 1 high only for a zero, unit 2 low
  assign pwm_level = (phase_i == 2'd0) || ((phase_i == 2'd1) && !bit_i);

  always_comb begin
    data_o = 1'b0;
    clk_o  = 1'b0;
    if (busy_i) begin
      if (link_i == LINK_TWO_WIRE) begin
        data_o = bit_i;
        clk_o  = (phase_i == 2'd0);
      end else begin
        data_o = pwm_level;
      end
    end
  end
endmodule

// File: rtl/evt_msg_ser.sv
module evt_msg_ser
  import evt_msg_pkg::*;
#(
  parameter int unsigned UNIT_CYC    = 40000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_i,
  input  logic       kind_i,
  input  logic       two_wire_i,
  input  logic [3:0] func_i,
  input  logic       vlow_i,
  input  logic       rpt_i,
  input  logic [1:0] txcnt_i,
  input  logic       lrn_ok_i,
  input  logic       lrn_ovw_i,
  output logic       data_o,
  output logic       clk_o,
  output logic       busy_o
);
  logic       rst_sync_n;
  fields_t    fld;
  frame_t     frame;
  logic       tick, accept, cur_bit;
  logic [1:0] phase;
  link_e      link_q;

  evt_msg_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  assign fld = '{func: func_i, vlow: vlow_i, rpt: rpt_i, txcnt: txcnt_i,
                 lrn_ok: lrn_ok_i, lrn_ovw: lrn_ovw_i};

  evt_msg_frame u_frame (
    .kind_i(msg_e'(kind_i)), .fld_i(fld), .frame_o(frame)
  );

  evt_msg_prescale #(.UNIT_CYC(UNIT_CYC)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run_i(busy_o), .clr_i(accept), .tick_o(tick)
  );

  evt_msg_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .send_i(send_i),
    .link_i(link_e'(two_wire_i)), .frame_i(frame), .tick_i(tick),
    .accept_o(accept), .busy_o(busy_o), .link_o(link_q),
    .bit_o(cur_bit), .phase_o(phase)
  );

  evt_msg_enc u_enc (
    .busy_i(busy_o), .link_i(link_q), .bit_i(cur_bit), .phase_i(phase),
    .data_o(data_o), .clk_o(clk_o)
  );
endmodule

// File: rtl/evt_msg_ser_chk.sv
module evt_msg_ser_chk #(
  parameter int unsigned UNIT_CYC = 40000
) (
  input logic clk,
  input logic rst_n,
  input logic send_i,
  input logic data_o,
  input logic clk_o,
  input logic busy_o,
  input logic link_q
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!data_o && !clk_o)); // R1
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> data_o); // R4
  AST_ONE_WIRE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !link_q) |-> !clk_o); // R5
  AST_TWO_WIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && link_q && !clk_o) |-> $stable(data_o)); // R6
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == 10 * (link_q ? 2 : 3) * UNIT_CYC)); // R7
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(send_i)); // R8
endmodule

bind evt_msg_ser evt_msg_ser_chk #(.UNIT_CYC(UNIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .send_i(send_i), .data_o(data_o),
  .clk_o(clk_o), .busy_o(busy_o), .link_q(link_q)
);

// File: tb/evt_msg_ser_bench.sv
module evt_msg_ser_bench;
  localparam int unsigned UNIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send = 1'b0, kind = 1'b0, two = 1'b0, vlow = 1'b0, rpt = 1'b0;
  logic ok = 1'b0, ovw = 1'b0;
  logic [3:0] func = 4'h0;
  logic [1:0] txc = 2'b00;
  logic data_o, clk_o, busy_o;

  int vectors = 0;
  int fails = 0;

  typedef struct { bit d; bit c; string tag; } smp_t;
  smp_t q[$];

  always #5 clk = ~clk;

  evt_msg_ser #(.UNIT_CYC(UNIT)) u_evt_msg_ser (
    .clk(clk), .rst_n(rst_n), .send_i(send), .kind_i(kind), .two_wire_i(two),
    .func_i(func), .vlow_i(vlow), .rpt_i(rpt), .txcnt_i(txc),
    .lrn_ok_i(ok), .lrn_ovw_i(ovw), .data_o(data_o), .clk_o(clk_o), .busy_o(busy_o)
  );

  // reference: expected line levels, one entry per busy cycle
  function automatic void load_frame();
    bit [9:0] fr;
    string kt, mt;
    if (kind) fr = {1'b1, 4'b0000, ok, ovw, txc, 1'b1};       // R3
    else      fr = {1'b1, func, vlow, rpt, txc, 1'b1};        // R2
    mt = two ? "R6" : "R5";
    for (int i = 9; i >= 0; i--) begin
      bit b = fr[i];
      kt = (i == 9 || i == 0) ? "R4" : (kind ? "R3" : "R2");
      for (int p = 0; p < (two ? 2 : 3); p++) begin
        for (int u = 0; u < int'(UNIT); u++) begin
          smp_t s;
          if (two) begin s.d = b; s.c = (p == 0); end
          else begin s.d = (p == 0) || (p == 1 && !b); s.c = 1'b0; end
          s.tag = $sformatf("%s/%s bit%0d", kt, mt, 9 - i);
          q.push_back(s);
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() > 0) void'(q.pop_front());   // R8: strobes ignored while busy
    else if (send) load_frame();                   // R9/R10: fields taken at this edge
  end

  always @(negedge clk) begin
    bit eb, ed, ec;
    string tg;
    eb = (q.size() > 0);
    ed = eb ? q[0].d : 1'b0;
    ec = eb ? q[0].c : 1'b0;
    tg = eb ? q[0].tag : "R1 idle";
    vectors++;
    if (busy_o !== eb) begin
      fails++;
      $display("FAIL R7 busy at %0t: got %b expected %b", $time, busy_o, eb);
    end
    if (data_o !== ed || clk_o !== ec) begin
      fails++;
      $display("FAIL %s at %0t: data/clk got %b%b expected %b%b",
               tg, $time, data_o, clk_o, ed, ec);
    end
  end

  task automatic set_fields(bit k, bit tw, bit [3:0] f, bit v, bit r, bit [1:0] t,
                            bit o, bit w);
    kind = k; two = tw; func = f; vlow = v; rpt = r; txc = t; ok = o; ovw = w;
  endtask

  task automatic pulse_send();
    @(negedge clk); send = 1'b1;
    @(negedge clk); send = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2 R5: event, single wire, mixed bits, count three
    set_fields(0, 0, 4'b1010, 1, 0, 2'b10, 0, 0);
    pulse_send(); wait_idle();
    // R2 R6: event, two wire
    set_fields(0, 1, 4'b0101, 0, 1, 2'b01, 1, 1);
    pulse_send(); wait_idle();
    // R3 R5: learn, single wire, event fields all ones must not leak
    set_fields(1, 0, 4'b1111, 1, 1, 2'b11, 1, 0);
    pulse_send(); wait_idle();
    // R3 R6: learn, two wire, overwrite set, one transmitter
    set_fields(1, 1, 4'b1111, 1, 1, 2'b00, 0, 1);
    pulse_send(); wait_idle();
    // R4: event of all-zero body, only start and stop high
    set_fields(0, 0, 4'b0000, 0, 0, 2'b00, 0, 0);
    pulse_send(); wait_idle();

    // R8: strobes mid-frame with other kind and mode
    set_fields(0, 1, 4'b0011, 1, 0, 2'b10, 0, 0);
    pulse_send();
    repeat (11) @(negedge clk);
    set_fields(1, 0, 4'b1100, 0, 1, 2'b01, 1, 1);
    pulse_send();
    repeat (20) @(negedge clk);
    pulse_send();
    wait_idle();

    // R9: inputs change while a frame is in flight
    set_fields(0, 0, 4'b1001, 0, 1, 2'b11, 0, 0);
    pulse_send();
    repeat (8) @(negedge clk);
    set_fields(1, 1, 4'b0110, 1, 0, 2'b00, 1, 1);
    repeat (30) @(negedge clk);
    set_fields(0, 1, 4'b1111, 1, 1, 2'b01, 0, 1);
    wait_idle();

    // R10: strobe held high, back-to-back frames
    set_fields(0, 1, 4'b0111, 1, 1, 2'b10, 0, 0);
    @(negedge clk); send = 1'b1;
    repeat (30) @(negedge clk);
    set_fields(1, 0, 4'b0000, 0, 0, 2'b11, 1, 1);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    send = 1'b0;
    wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule